// File: doc/BRIEF.md
# I2C Byte Master with Idle Pauses

This block is a single-master I2C engine that works one command at a time. The commands are start, write byte, read byte and stop. The controlling logic hands in a command and waits for the done pulse. It may then leave the bus untouched for as long as it likes before the next command. Both bus lines are open-drain: the block only pulls a line low or lets it go, and the pull-up supplies the high level. While the block is not busy, SCL is held low, either by the master or by a stretching slave. SCL does not rise again until the next command, so a pause of any length cannot clock a bit into the slave.

Every bit slot has the same shape. SCL is pulled low for a fixed low count, and SDA is updated one clock after SCL falls. Then SCL is released and the block waits until the line reads high. A slave can therefore stretch any bit, not only the gap between bytes. The high phase is counted only from the moment SCL is seen high. The low and high counts come from the clock-to-bus frequency ratio, which suits standard mode (100 kHz) and fast mode (400 kHz). A timeout can be set to give up when SCL stays low too long after release.

Top module: `i2c_pause_master`

## Requirements
- R1: After reset, busy, done and timeout are 0 and both scl_oe and sda_oe are 0 (lines released).
- R2: A start on a free bus pulls SDA low while SCL is high, then pulls SCL low. At done the bus sits with both lines low.
- R3: A write (cmd_op = 1) shifts cmd_data onto SDA, most significant bit first, one bit per SCL high phase. It then releases SDA for a ninth bit. At done, rx_ack holds the level sampled on that ninth bit (0 = acknowledged) and rx_data holds the eight bus bits.
- R4: A read (cmd_op = 2) releases SDA for eight bits and presents the sampled byte on rx_data at done, most significant bit first. On the ninth bit it pulls SDA low when cmd_nack = 0 and releases it when cmd_nack = 1.
- R5: A stop (cmd_op = 3) on a held bus pulls SDA low during a low phase, releases SCL, then releases SDA while SCL is high. At done both lines are released.
- R6: Between commands (busy = 0) scl_oe does not change. After a start, write or read, SCL stays low with no rising edge however long the pause lasts.
- R7: The master counts its high phase only after SCL reads high. Every SCL high pulse of a byte transfer therefore lasts exactly HIGH_CYC + 1 clocks, whether or not the slave stretched the preceding low phase.
- R8: During a write or read, SDA changes only while SCL is low, so no start or stop condition appears inside a byte.
- R9: A start (cmd_op = 0) while the bus is held performs a repeated start. SDA is released during a low phase, SCL rises, and then SDA falls while SCL is high, with no stop in between.
- R10: A stop on a free bus finishes with done in the cycle after acceptance and leaves both lines untouched.
- R11: With TIMEOUT_CYC > 0, suppose SCL is still low TIMEOUT_CYC clocks after the master released it. The master then sets timeout, releases both lines, pulses done and returns to a free bus. If SCL reads high in the cycle that would expire the limit, the release wins and no timeout is set. The next accepted command clears timeout.
- R12: A command is accepted when cmd_valid is 1 and busy is 0. cmd_valid while busy is 1 is ignored. done is a one-cycle pulse and busy is 0 when it is high.
- R13: With P = CLK_HZ / SCL_HZ, the low phase is LOW_CYC = (P + 1) / 2 clocks and the high count is HIGH_CYC = P - LOW_CYC. An unstretched low between two bits of a byte lasts exactly LOW_CYC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is 0 |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_data | input | 8 | Byte to write |
| cmd_nack | input | 1 | Read: 1 releases SDA on the ninth bit (not-acknowledge) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Eight data bits seen on the bus in the last byte |
| rx_ack | output | 1 | Ninth bit seen on the bus (0 = acknowledge) |
| timeout | output | 1 | SCL held low past the limit; cleared by the next command |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_in | input | 1 | SCL level read from the bus, already synchronized |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | SDA level read from the bus, already synchronized |

## Verification
Two functions can fall in the same cycle: the slave ending a stretch and the timeout expiring. The bench's slave model holds SCL for a chosen number of clocks after each falling edge. Arithmetic from LOW_CYC and TIMEOUT_CYC gives a stretch of LOW_CYC + TIMEOUT_CYC - 2, whose release is first seen in the cycle where the limit would run out. With that stretch the byte must complete with timeout clear and the correct data on the bus. One clock more must end in timeout, with both lines released and done pulsed. Around this case, full sweeps of written and read bytes with mixed stretching and pauses confirm the pulse widths and the absence of edges during pauses.

// File: rtl/i2c_pause_master.sv
module i2c_pause_master #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SCL_HZ      = 100_000,
  parameter int TIMEOUT_CYC = 1_750_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_nack,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       rx_ack,
  output logic       timeout,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int PERIOD   = CLK_HZ / SCL_HZ;
  localparam int LOW_CYC  = (PERIOD + 1) / 2;
  localparam int HIGH_CYC = PERIOD - LOW_CYC;
  localparam int PH_MAX   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CNT_MAX  = (TIMEOUT_CYC > PH_MAX) ? TIMEOUT_CYC : PH_MAX;
  localparam int CW       = $clog2(CNT_MAX + 1);

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_RISE, S_HIGH, S_HOLD, S_FREE} state_t;

  state_t        state;
  logic [1:0]    op;
  logic [7:0]    tx;
  logic          nack_r;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt;
  logic [8:0]    sh;
  logic          active, done_r, to_r, scl_r, sda_r;
  logic          sda_slot;

  wire low_end  = (cnt == CW'(LOW_CYC - 1));
  wire high_end = (cnt == CW'(HIGH_CYC - 1));
  wire tmo_hit  = (TIMEOUT_CYC != 0) && (cnt == CW'(TIMEOUT_CYC - 1));

  always_comb begin
    case (op)
      OP_START: sda_slot = 1'b0;
      OP_STOP:  sda_slot = 1'b1;
      OP_WRITE: sda_slot = bitn[3] ? 1'b0 : ~tx[3'd7 - bitn[2:0]];
      default:  sda_slot = bitn[3] ? ~nack_r : 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op     <= OP_START;
      tx     <= '0;
      nack_r <= 1'b0;
      bitn   <= '0;
      cnt    <= '0;
      sh     <= '0;
      active <= 1'b0;
      done_r <= 1'b0;
      to_r   <= 1'b0;
      scl_r  <= 1'b0;
      sda_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          to_r   <= 1'b0;
          op     <= cmd_op;
          tx     <= cmd_data;
          nack_r <= cmd_nack;
          bitn   <= '0;
          cnt    <= '0;
          if (cmd_op == OP_START && !active) begin
            sda_r <= 1'b1;
            state <= S_HOLD;
          end else if (cmd_op == OP_STOP && !active) begin
            done_r <= 1'b1;
          end else begin
            state <= S_LOW;
          end
        end
        S_LOW: begin
          if (cnt == '0) sda_r <= sda_slot;
          if (low_end) begin
            scl_r <= 1'b0;
            cnt   <= '0;
            state <= S_RISE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RISE: begin
          if (scl_in) begin
            cnt   <= '0;
            state <= S_HIGH;
          end else if (tmo_hit) begin
            to_r   <= 1'b1;
            scl_r  <= 1'b0;
            sda_r  <= 1'b0;
            active <= 1'b0;
            done_r <= 1'b1;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (high_end) begin
            cnt <= '0;
            case (op)
              OP_START: begin sda_r <= 1'b1; state <= S_HOLD; end
              OP_STOP:  begin sda_r <= 1'b0; state <= S_FREE; end
              default: begin
                sh    <= {sh[7:0], sda_in};
                scl_r <= 1'b1;
                if (bitn == 4'd8) begin
                  done_r <= 1'b1;
                  state  <= S_IDLE;
                end else begin
                  bitn  <= bitn + 1'b1;
                  state <= S_LOW;
                end
              end
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (high_end) begin
            scl_r  <= 1'b1;
            active <= 1'b1;
            done_r <= 1'b1;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FREE: begin
          if (high_end) begin
            active <= 1'b0;
            done_r <= 1'b1;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = done_r;
  assign timeout = to_r;
  assign scl_oe  = scl_r;
  assign sda_oe  = sda_r;
  assign rx_data = sh[8:1];
  assign rx_ack  = sh[0];
endmodule

// File: rtl/i2c_pause_master_chk.sv
module i2c_pause_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_in
);
  p_pause_scl_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(scl_oe));

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> (busy || done));

  p_wait_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && $past(!scl_oe) && !$past(scl_in)) |-> !scl_oe);

  p_timeout_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (!scl_oe && !sda_oe && done));
endmodule

bind i2c_pause_master i2c_pause_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .timeout(timeout), .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in)
);

// File: tb/i2c_pause_master_bench.sv
module i2c_pause_master_bench;
  localparam int CLK_HZ = 900;
  localparam int SCL_HZ = 100;
  localparam int TO     = 40;
  localparam int P      = CLK_HZ / SCL_HZ;
  localparam int LOWC   = (P + 1) / 2;
  localparam int HIGHC  = P - LOWC;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       cmd_nack = 1'b0;
  logic       busy, done, rx_ack, timeout, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic       scl_line, sda_line, slave_sda_low;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int mode = 0;
  bit ack_en = 1'b0;
  logic [7:0] rd_byte = 8'd0;
  int slot = 0, bitn = 0, starts = 0, stops = 0, rises = 0;
  logic [8:0] cap = '0;
  logic [7:0] got_byte = '0;
  logic got_ack = 1'b0;
  logic ps = 1'b1, pd = 1'b1;
  int stretch_n = 0;
  int hold = 0;
  logic sclp = 1'b1;

  assign scl_line = ~(scl_oe | (hold != 0));
  assign slave_sda_low = (mode == 1 && slot == 8 && ack_en) ||
                         (mode == 2 && slot < 8 && !rd_byte[(7 - slot) & 7]);
  assign sda_line = ~(sda_oe | slave_sda_low);

  i2c_pause_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .TIMEOUT_CYC(TO)) u_i2c_pause_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack), .busy(busy), .done(done),
    .rx_data(rx_data), .rx_ack(rx_ack), .timeout(timeout), .scl_oe(scl_oe),
    .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model: start/stop detection, bit capture, data/ack drive
  always @(scl_line or sda_line) begin
    if (scl_line !== ps) begin
      if (scl_line === 1'b1) begin
        rises++;
        cap = {cap[7:0], sda_line};
        if (bitn == 8) begin
          got_byte = cap[8:1];
          got_ack  = cap[0];
          bitn = 0;
        end else begin
          bitn++;
        end
      end else begin
        slot = bitn;
      end
    end else if (sda_line !== pd && scl_line === 1'b1) begin
      if (sda_line === 1'b0) begin starts++; bitn = 0; end
      else if (sda_line === 1'b1) stops++;
    end
    ps = scl_line;
    pd = sda_line;
  end

  // slave clock stretching
  always @(posedge clk) begin
    sclp <= scl_line;
    if (sclp === 1'b1 && scl_line === 1'b0 && stretch_n != 0) hold <= stretch_n;
    else if (hold != 0) hold <= hold - 1;
  end

  // pulse-width monitor
  logic pm = 1'b1;
  int hi_len = 0, lo_len = 0;
  bit lo_track = 1'b0;
  bit in_byte = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (scl_line === 1'b1) begin
      if (pm === 1'b0) begin
        if (in_byte && lo_track && stretch_n == 0)
          chk(lo_len == LOWC, "R13 low phase length", lo_len, LOWC);
        hi_len = 0;
      end
      hi_len++;
    end else begin
      if (pm === 1'b1) begin
        if (in_byte) chk(hi_len == HIGHC + 1, "R7 high phase length", hi_len, HIGHC + 1);
        lo_track = busy;
        lo_len = 0;
      end
      lo_len++;
    end
    pm = scl_line;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] d, input logic nk,
                        input bit poke, output int lat);
    @(negedge clk);
    chk(!busy, "R12 idle before command", busy, 0);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_nack = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy || done, "R12 accepted", busy, 1);
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
      cmd_valid = poke && (lat == 20);
      if (poke) cmd_op = 2'd3;
    end
    cmd_valid = 1'b0;
    chk(!busy, "R12 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R12 done one cycle", done, 0);
  endtask

  task automatic pause(input int n);
    int r0;
    r0 = rises;
    repeat (n) @(negedge clk);
    chk(rises == r0 && scl_line == 1'b0, "R6 no SCL edge in pause", rises - r0, 0);
  endtask

  task automatic wr(input logic [7:0] b, input bit ack, input bit poke);
    int s0, p0, lat;
    s0 = starts; p0 = stops;
    mode = 1; ack_en = ack; in_byte = 1'b1;
    do_cmd(2'd1, b, 1'b0, poke, lat);
    chk(got_byte == b, "R3 byte on bus", got_byte, b);
    chk(rx_ack == !ack, "R3 ack bit", rx_ack, !ack);
    chk(rx_data == b, "R3 rx_data bus byte", rx_data, b);
    chk(starts == s0 && stops == p0, "R8 no start/stop in byte", stops - p0, 0);
    if (poke) chk(busy == 1'b0 && stops == p0, "R12 command while busy ignored", stops - p0, 0);
    chk(timeout == 1'b0, "R11 no timeout", timeout, 0);
    @(negedge clk);
    in_byte = 1'b0;
  endtask

  task automatic rd(input logic [7:0] v, input logic nk);
    int s0, p0, lat;
    s0 = starts; p0 = stops;
    mode = 2; rd_byte = v; in_byte = 1'b1;
    do_cmd(2'd2, 8'd0, nk, 1'b0, lat);
    chk(rx_data == v, "R4 read data", rx_data, v);
    chk(got_ack == nk, "R4 ninth bit from master", got_ack, nk);
    chk(starts == s0 && stops == p0, "R8 no start/stop in read", stops - p0, 0);
    @(negedge clk);
    in_byte = 1'b0;
  endtask

  task automatic do_start_free();
    int s0, lat;
    s0 = starts;
    do_cmd(2'd0, 8'd0, 1'b0, 1'b0, lat);
    chk(starts == s0 + 1, "R2 start seen", starts - s0, 1);
    chk(scl_line == 1'b0 && sda_line == 1'b0, "R2 lines low after start", scl_line, 0);
  endtask

  task automatic do_stop();
    int p0, lat;
    p0 = stops;
    mode = 0; ack_en = 1'b0;
    do_cmd(2'd3, 8'd0, 1'b0, 1'b0, lat);
    chk(stops == p0 + 1, "R5 stop seen", stops - p0, 1);
    chk(scl_line && sda_line && !scl_oe && !sda_oe, "R5 lines released", scl_oe, 0);
  endtask

  initial begin
    int lat, s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !timeout, "R1 reset flags", busy, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released", scl_oe, 0);

    do_start_free();
    for (int b = 0; b < 256; b++) begin
      stretch_n = (b % 3 == 0) ? 12 : 0;
      wr(b[7:0], (b % 4) != 3, b == 100);
      pause((b % 5) * 30);
    end
    stretch_n = 0;
    pause(30);
    do_stop();

    s0 = starts; p0 = stops;
    do_cmd(2'd3, 8'd0, 1'b0, 1'b0, lat);
    chk(lat == 0, "R10 stop on free bus immediate", lat, 0);
    chk(starts == s0 && stops == p0 && scl_line && sda_line, "R10 lines untouched", stops - p0, 0);

    do_start_free();
    for (int i = 0; i < 64; i++) begin
      rd(8'((i * 37 + 11) & 255), 1'(i % 2));
      pause((i % 4) * 25);
    end
    do_stop();

    do_start_free();
    wr(8'hA5, 1'b1, 1'b0);
    mode = 0;
    s0 = starts; p0 = stops;
    do_cmd(2'd0, 8'd0, 1'b0, 1'b0, lat);
    chk(starts == s0 + 1 && stops == p0, "R9 repeated start", starts - s0, 1);
    chk(scl_line == 1'b0, "R9 SCL held after repeated start", scl_line, 0);

    stretch_n = LOWC + TO - 2;
    wr(8'h3C, 1'b1, 1'b0);
    chk(timeout == 1'b0, "R11 release in limit cycle wins", timeout, 0);
    stretch_n = LOWC + TO - 1;
    pause(60);
    mode = 1; ack_en = 1'b1; in_byte = 1'b1;
    do_cmd(2'd1, 8'hC3, 1'b0, 1'b0, lat);
    chk(timeout == 1'b1, "R11 timeout set", timeout, 1);
    chk(!scl_oe && !sda_oe, "R11 lines released on timeout", scl_oe, 0);
    in_byte = 1'b0;
    stretch_n = 0; mode = 0;
    repeat (60) @(negedge clk);
    chk(scl_line == 1'b1 && sda_line == 1'b1, "R11 bus free after timeout", scl_line, 1);
    do_start_free();
    chk(timeout == 1'b0, "R11 timeout cleared by command", timeout, 0);
    do_stop();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule